// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block runs one SD-card command transaction in SPI mode over a byte-wide exchange port. A host sets up a command index, a 32-bit argument, a check byte and the number of reply bytes expected after the status byte, then pulses a start strobe while the engine is idle. The engine pulls chip select low and sends the six-byte command frame. It then clocks out all-ones filler bytes until the card returns a byte whose top bit is clear, which it stores as the status byte. If the caller asked for them, it reads further reply bytes and packs them into a word. Finally it raises chip select and sends one more filler byte so the card can release its data output.

The SPI bit shifter sits outside the block and is reached through a request/complete handshake. Each handshake moves one byte out and one byte in. An option leaves chip select low after a successful reply, so that a data-block phase handled by other logic can follow straight on. When a transaction ends, a one-cycle `done` pulse marks the status byte, the packed reply word and the timeout flag as valid. These outputs then hold until the next request is accepted.

Top module: `sdcmd_engine`

## Requirements
- R1: During and after reset, `spi_cs_n` is 1 and `xfer_req`, `busy` and `done` are 0.
- R2: An accepted request sends exactly six bytes with `spi_cs_n` at 0, in this order:
  - `{2'b01, cmd_index}`;
  - the argument, bits 31:24 first and bits 7:0 last;
  - `cmd_crc`.
  Inputs are latched at acceptance, so changing them later has no effect.
- R3: After the frame the engine sends 0xFF poll bytes. The first received byte with bit 7 equal to 0 becomes `r1_status`. A received byte with bit 7 set, 0x80 included, is skipped and polling goes on.
- R4: If POLL_LIMIT poll bytes all arrive with bit 7 set, the engine releases the bus and reports:
  - `timed_out` = 1;
  - `r1_status` = 0xFF;
  - `reply_word` = 0.
  A valid byte received on exchange number POLL_LIMIT is still accepted.
- R5: After a valid status byte the engine reads `reply_extra` more bytes by sending 0xFF; values above TAIL_BYTES count as TAIL_BYTES. The bytes are packed first-received-most-significant and right-aligned, so the last byte lands in bits 7:0. With a count of 0, `reply_word` is 0.
- R6: Without the hold option, and always after a timeout, the last exchange of a transaction is one 0xFF byte sent with `spi_cs_n` at 1. `done` follows it, and `spi_cs_n` stays 1 afterwards.
- R7: With `hold_select` at 1 and a valid reply, there is no release byte and `spi_cs_n` stays 0 after `done`.
- R8: `done` is a one-cycle pulse that comes with `busy` at 0. `r1_status`, `reply_word` and `timed_out` hold their values until the next accepted request.
- R9: `req_start` has no effect while `busy` is 1. No frame is restarted and no extra exchange occurs.
- R10: Only one exchange is outstanding at a time. `xfer_req` and `xfer_tx` hold steady until `xfer_done`, and the total number of exchanges per transaction is exactly what R2 to R7 imply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start strobe, taken only while idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_crc | input | 8 | Check byte placed last in the frame |
| reply_extra | input | 3 | Reply bytes to read after the status byte |
| hold_select | input | 1 | Keep chip select low after a valid reply |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| r1_status | output | 8 | Status byte received (0xFF on timeout) |
| reply_word | output | 32 | Packed trailing reply bytes |
| timed_out | output | 1 | No valid reply within the poll limit |
| spi_cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | Byte exchange request to the shifter |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Shifter has completed the exchange |
| xfer_rx | input | 8 | Byte shifted in |

## Verification
The assertions assume the shifter raises `xfer_done` only while `xfer_req` is high, for one cycle per exchange, and never before the cycle after the request. The bench's card model follows this rule. It answers every request after a negedge and drops `xfer_done` at the next one. It also presents `req_start` only on negedge boundaries. Stimulus stays inside the 0 to 7 range of `reply_extra` and covers both sides of the poll limit.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int ARG_BYTES   = 4;
  localparam int ARG_W       = 8 * ARG_BYTES;
  localparam int FRAME_BYTES = ARG_BYTES + 2;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [1:0] START_BITS = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_POLL,
    ST_TAIL,
    ST_RELEASE
  } eng_state_t;
endpackage

// File: rtl/sdcmd_frame_mux.sv
module sdcmd_frame_mux
  import sdcmd_pkg::*;
(
  input  logic [5:0]       cmd,
  input  logic [ARG_W-1:0] arg,
  input  logic [7:0]       crc,
  input  logic [IDX_W-1:0] sel,
  output logic [7:0]       byte_o
);
  logic [7:0] lane [FRAME_BYTES];

  assign lane[0]             = {START_BITS, cmd};
  assign lane[FRAME_BYTES-1] = crc;

  // argument lanes, most significant byte first on the wire
  for (genvar i = 0; i < ARG_BYTES; i++) begin : g_arg_lane
    assign lane[i+1] = arg[8*(ARG_BYTES-i)-1 -: 8];
  end

  always_comb begin
    byte_o = FILL_BYTE;
    for (int k = 0; k < FRAME_BYTES; k++) begin
      if (sel == IDX_W'(k)) byte_o = lane[k];
    end
  end
endmodule

// File: rtl/sdcmd_byte_port.sv
module sdcmd_byte_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [7:0] issue_byte,
  output logic       xfer_req,
  output logic [7:0] xfer_tx,
  input  logic       xfer_done,
  input  logic [7:0] xfer_rx,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_req <= 1'b0;
      xfer_tx  <= 8'hFF;
      rx_valid <= 1'b0;
      rx_byte  <= 8'hFF;
    end else begin
      rx_valid <= 1'b0;
      if (xfer_req && xfer_done) begin
        xfer_req <= 1'b0;
        rx_valid <= 1'b1;
        rx_byte  <= xfer_rx;
      end else if (issue && !xfer_req) begin
        xfer_req <= 1'b1;
        xfer_tx  <= issue_byte;
      end
    end
  end
endmodule

// File: rtl/sdcmd_poll_timer.sv
module sdcmd_poll_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] END_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + CW'(1);
  end

  assign last = (cnt == END_V);
endmodule

// File: rtl/sdcmd_reply_capture.sv
module sdcmd_reply_capture #(
  parameter int TAIL_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    load_r1,
  input  logic [7:0]              r1_in,
  input  logic                    shift,
  input  logic [7:0]              byte_in,
  output logic [7:0]              r1,
  output logic [8*TAIL_BYTES-1:0] tail
);
  localparam int TW = 8 * TAIL_BYTES;

  always_ff @(posedge clk) begin
    if (rst || clear)  r1 <= '0;
    else if (load_r1)  r1 <= r1_in;
  end

  if (TAIL_BYTES == 1) begin : g_tail_one
    always_ff @(posedge clk) begin
      if (rst || clear) tail <= '0;
      else if (shift)   tail <= byte_in;
    end
  end else begin : g_tail_many
    always_ff @(posedge clk) begin
      if (rst || clear) tail <= '0;
      else if (shift)   tail <= {tail[TW-9:0], byte_in};
    end
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 5000,
  parameter int TAIL_BYTES = 4,
  parameter int EXTRA_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_start,
  input  logic [5:0]              cmd_index,
  input  logic [ARG_W-1:0]        cmd_arg,
  input  logic [7:0]              cmd_crc,
  input  logic [EXTRA_W-1:0]      reply_extra,
  input  logic                    hold_select,
  output logic                    busy,
  output logic                    done,
  output logic [7:0]              r1_status,
  output logic [8*TAIL_BYTES-1:0] reply_word,
  output logic                    timed_out,
  output logic                    spi_cs_n,
  output logic                    xfer_req,
  output logic [7:0]              xfer_tx,
  input  logic                    xfer_done,
  input  logic [7:0]              xfer_rx
);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [EXTRA_W-1:0] TAIL_CAP = EXTRA_W'(TAIL_BYTES);

  eng_state_t         state;
  logic [5:0]         cmd_q;
  logic [ARG_W-1:0]   arg_q;
  logic [7:0]         crc_q;
  logic [IDX_W-1:0]   fidx;
  logic [EXTRA_W-1:0] tail_left;
  logic               keep_q;
  logic               kick;
  logic [7:0]         kick_byte;

  logic               rx_valid;
  logic [7:0]         rx_byte;
  logic [7:0]         next_frame_byte;
  logic [EXTRA_W-1:0] extra_sat;

  logic cap_clear, cap_r1_load, cap_shift;
  logic [7:0] cap_r1_val;
  logic pt_step, pt_last;

  sdcmd_byte_port u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (kick),
    .issue_byte (kick_byte),
    .xfer_req   (xfer_req),
    .xfer_tx    (xfer_tx),
    .xfer_done  (xfer_done),
    .xfer_rx    (xfer_rx),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte)
  );

  sdcmd_frame_mux u_frame (
    .cmd    (cmd_q),
    .arg    (arg_q),
    .crc    (crc_q),
    .sel    (fidx + IDX_W'(1)),
    .byte_o (next_frame_byte)
  );

  sdcmd_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (cap_clear),
    .step  (pt_step),
    .last  (pt_last)
  );

  sdcmd_reply_capture #(.TAIL_BYTES(TAIL_BYTES)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .clear   (cap_clear),
    .load_r1 (cap_r1_load),
    .r1_in   (cap_r1_val),
    .shift   (cap_shift),
    .byte_in (rx_byte),
    .r1      (r1_status),
    .tail    (reply_word)
  );

  assign extra_sat = (reply_extra > TAIL_CAP) ? TAIL_CAP : reply_extra;

  always_comb begin
    cap_clear   = (state == ST_IDLE) && req_start;
    cap_r1_load = (state == ST_POLL) && rx_valid && (!rx_byte[7] || pt_last);
    cap_r1_val  = rx_byte[7] ? FILL_BYTE : rx_byte;
    pt_step     = (state == ST_POLL) && rx_valid && rx_byte[7] && !pt_last;
    cap_shift   = (state == ST_TAIL) && rx_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_q     <= '0;
      arg_q     <= '0;
      crc_q     <= '0;
      fidx      <= '0;
      tail_left <= '0;
      keep_q    <= 1'b0;
      kick      <= 1'b0;
      kick_byte <= FILL_BYTE;
      busy      <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      spi_cs_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      kick <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_start) begin
            cmd_q     <= cmd_index;
            arg_q     <= cmd_arg;
            crc_q     <= cmd_crc;
            keep_q    <= hold_select;
            tail_left <= extra_sat;
            timed_out <= 1'b0;
            spi_cs_n  <= 1'b0;
            busy      <= 1'b1;
            fidx      <= '0;
            kick      <= 1'b1;
            kick_byte <= {START_BITS, cmd_index};
            state     <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (rx_valid) begin
            kick <= 1'b1;
            if (fidx == LAST_IDX) begin
              kick_byte <= FILL_BYTE;
              state     <= ST_POLL;
            end else begin
              fidx      <= fidx + IDX_W'(1);
              kick_byte <= next_frame_byte;
            end
          end
        end
        ST_POLL: begin
          if (rx_valid) begin
            if (!rx_byte[7]) begin
              if (tail_left != '0) begin
                kick      <= 1'b1;
                kick_byte <= FILL_BYTE;
                state     <= ST_TAIL;
              end else if (keep_q) begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else begin
                spi_cs_n  <= 1'b1;
                kick      <= 1'b1;
                kick_byte <= FILL_BYTE;
                state     <= ST_RELEASE;
              end
            end else if (pt_last) begin
              timed_out <= 1'b1;
              spi_cs_n  <= 1'b1;
              kick      <= 1'b1;
              kick_byte <= FILL_BYTE;
              state     <= ST_RELEASE;
            end else begin
              kick      <= 1'b1;
              kick_byte <= FILL_BYTE;
            end
          end
        end
        ST_TAIL: begin
          if (rx_valid) begin
            tail_left <= tail_left - EXTRA_W'(1);
            if (tail_left != EXTRA_W'(1)) begin
              kick      <= 1'b1;
              kick_byte <= FILL_BYTE;
            end else if (keep_q) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              spi_cs_n  <= 1'b1;
              kick      <= 1'b1;
              kick_byte <= FILL_BYTE;
              state     <= ST_RELEASE;
            end
          end
        end
        ST_RELEASE: begin
          if (rx_valid) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_start,
  input logic       busy,
  input logic       done,
  input logic [7:0] r1_status,
  input logic [31:0] reply_word,
  input logic       timed_out,
  input logic       spi_cs_n,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_done
);
  // R10: an outstanding exchange keeps its request and byte until completion
  a_r10_hold_exchange: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));

  // R6: anything shifted with chip select released is filler
  a_r6_release_fill: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && spi_cs_n) |-> (xfer_tx == 8'hFF));

  // R8: completion marker lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: completion comes with the engine idle and no exchange pending
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !xfer_req));

  // R8: results hold while idle
  a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> ($stable(r1_status) && $stable(reply_word) && $stable(timed_out)));

  // R4: timeout reports the fill status and leaves the card deselected
  a_r4_timeout_fill: assert property (@(posedge clk) disable iff (rst)
    (done && timed_out) |-> (r1_status == 8'hFF && spi_cs_n));

  // R3: an accepted status byte has bit 7 clear
  a_r3_status_msb: assert property (@(posedge clk) disable iff (rst)
    (done && !timed_out) |-> !r1_status[7]);

  // R9: exchanges only happen inside a transaction
  a_r9_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> busy);
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_start  (req_start),
  .busy       (busy),
  .done       (done),
  .r1_status  (r1_status),
  .reply_word (reply_word),
  .timed_out  (timed_out),
  .spi_cs_n   (spi_cs_n),
  .xfer_req   (xfer_req),
  .xfer_tx    (xfer_tx),
  .xfer_done  (xfer_done)
);

// File: tb/sim_sdcmd_engine.sv
`timescale 1ns/100ps
module sim_sdcmd_engine;
  localparam int LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  cmd_crc = '0;
  logic [2:0]  reply_extra = '0;
  logic        hold_select = 1'b0;
  logic        busy, done, timed_out, spi_cs_n, xfer_req;
  logic [7:0]  r1_status, xfer_tx;
  logic [31:0] reply_word;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;

  always #2.5 clk = ~clk;

  sdcmd_engine #(.POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .req_start(req_start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .cmd_crc(cmd_crc), .reply_extra(reply_extra),
    .hold_select(hold_select), .busy(busy), .done(done), .r1_status(r1_status),
    .reply_word(reply_word), .timed_out(timed_out), .spi_cs_n(spi_cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx)
  );

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  // card model state, reference stream and observation counters
  int          cur_lat, cur_ntail, xk, xcount, mism;
  logic [7:0]  cur_r1;
  logic [31:0] cur_tw;
  logic [8:0]  expq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] card_byte(input int k);
    int p, j;
    if (k < 6) return 8'hFF;
    p = k - 6;
    if (p < cur_lat) return (p == 0) ? 8'h80 : 8'hFF;
    if (p == cur_lat) return cur_r1;
    j = p - cur_lat;
    if (j <= cur_ntail) return cur_tw[8*(5-j)-1 -: 8];
    return 8'hFF;
  endfunction

  // card side of the byte exchange: compare each shifted byte to the reference
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_done) begin
        xfer_done = 1'b0;
      end else if (xfer_req) begin
        if (expq.size() == 0) mism++;
        else if ({spi_cs_n, xfer_tx} !== expq.pop_front()) mism++;
        xfer_rx   = card_byte(xk);
        xk++;
        xcount++;
        xfer_done = 1'b1;
      end
    end
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc,
                         input logic [2:0] extra, input bit keep, input int lat,
                         input logic [7:0] r1, input logic [31:0] tw, input bit poke);
    int nsat, npoll, nexp, cyc;
    bit ok;
    logic [7:0]  exp_r1;
    logic [31:0] exp_tail;
    nsat = (extra > 3'd4) ? 4 : int'(extra);
    ok   = (lat < LIMIT);
    cur_lat = lat; cur_r1 = r1; cur_tw = tw; cur_ntail = nsat;
    expq.delete();
    expq.push_back({1'b0, 2'b01, idx});
    for (int b = 3; b >= 0; b--) expq.push_back({1'b0, arg[8*b +: 8]});
    expq.push_back({1'b0, crc});
    npoll = ok ? lat + 1 : LIMIT;
    for (int i = 0; i < npoll; i++) expq.push_back(9'h0FF);
    if (ok) for (int i = 0; i < nsat; i++) expq.push_back(9'h0FF);
    if (!(keep && ok)) expq.push_back(9'h1FF);
    nexp     = expq.size();
    exp_r1   = ok ? r1 : 8'hFF;
    exp_tail = (ok && nsat != 0) ? (tw >> (8 * (4 - nsat))) : 32'h0;
    xk = 0; xcount = 0; mism = 0;

    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; cmd_crc = crc; reply_extra = extra; hold_select = keep;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    // R2: later input changes must not reach the frame
    cmd_index = ~idx; cmd_arg = ~arg; cmd_crc = ~crc; reply_extra = 3'd0; hold_select = ~keep;
    cyc = 0;
    while (!done && cyc < 60000) begin
      if (poke && cyc == 3) req_start = 1'b1;  // R9: start while busy
      @(negedge clk);
      req_start = 1'b0;
      cyc++;
    end
    chk(done === 1'b1, "R8 done seen", done, 1);
    chk(r1_status === exp_r1, ok ? "R3 status byte" : "R4 timeout status", r1_status, exp_r1);
    chk(timed_out === !ok, "R4 timeout flag", timed_out, !ok);
    chk(reply_word === exp_tail, "R5 reply word", reply_word, exp_tail);
    chk(mism == 0 && expq.size() == 0, "R2 byte stream", mism, 0);
    chk(xcount == nexp, "R10 exchange count", xcount, nexp);
    chk(spi_cs_n === !(keep && ok), (keep && ok) ? "R7 select held" : "R6 select released",
        spi_cs_n, !(keep && ok));
    chk(busy === 1'b0, "R8 idle with done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", done, 0);
    repeat (8) @(negedge clk);
    chk(r1_status === exp_r1 && reply_word === exp_tail, "R8 results held", r1_status, exp_r1);
    chk(xcount == nexp && busy === 1'b0, "R9 no extra activity", xcount, nexp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(spi_cs_n === 1'b1, "R1 cs in reset", spi_cs_n, 1);
    chk(xfer_req === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 idle in reset", {xfer_req, busy, done}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(spi_cs_n === 1'b1 && busy === 1'b0, "R1 after reset", {spi_cs_n, busy}, 2);

    run_cmd(6'd0,  32'h0000_0000, 8'h95, 3'd0, 1'b0, 1, 8'h01, 32'h0, 1'b0);           // R3 skip 0x80
    run_cmd(6'd8,  32'h0000_01AA, 8'h87, 3'd4, 1'b0, 0, 8'h01, 32'h0000_01AA, 1'b0);    // R5 four bytes
    run_cmd(6'd58, 32'h0000_0000, 8'h95, 3'd4, 1'b0, 3, 8'h00, 32'hC0FF_8000, 1'b0);    // R5 packing
    run_cmd(6'd13, 32'hA5C3_1E0F, 8'h3B, 3'd2, 1'b0, 2, 8'h04, 32'h1234_5678, 1'b0);    // R5 partial
    run_cmd(6'd55, 32'h8000_0001, 8'h11, 3'd7, 1'b0, 0, 8'h7E, 32'hDEAD_BEEF, 1'b0);    // R5 saturate
    run_cmd(6'd9,  32'h0000_0000, 8'h95, 3'd0, 1'b1, 4, 8'h00, 32'h0, 1'b0);            // R7 hold
    run_cmd(6'd17, 32'h0000_0200, 8'h95, 3'd0, 1'b0, 1, 8'h00, 32'h0, 1'b1);            // R9 poke
    run_cmd(6'd41, 32'h4000_0000, 8'h95, 3'd0, 1'b0, LIMIT - 1, 8'h00, 32'h0, 1'b0);    // R4 boundary
    run_cmd(6'd24, 32'h0000_1000, 8'h95, 3'd4, 1'b1, LIMIT, 8'h00, 32'h0, 1'b0);        // R4 timeout, R7 release

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule